// File: doc/BRIEF.md
# Subcode Q-Channel Word Validator

This block gathers the Q bits of a disc subcode stream into a 96-bit word, one bit per subcode frame, and tests each complete word with a 16-bit cyclic redundancy check before it lets a host see it. An upstream circuit supplies the Q bit, a strobe that marks each new bit, and a marker that starts a new block. The block does no sync detection and does not handle the other subcode channels.

A word that passes is copied into a holding register, and an active-low ready flag drops. The host then shifts the word out, MSB first, through a strobed serial read port. A word that fails is never exposed. A configuration input selects which of two output pins carries the ready flag. Accumulation keeps running into its own shift register while a read is in progress, so the word being read out is never disturbed.

Top module: `subq_validator`

## Requirements
- R1: After reset, no read is in progress, the ready flag is high (not ready), and both `sda_out` and `status_out` are 1.
- R2: Each strobe shifts one bit into the word, MSB first (the first bit after a block marker becomes bit 95). A block marker restarts accumulation. A strobe in the same cycle as the marker is ignored, and strobes after the 96th bit are ignored until the next marker.
- R3: The check value is computed over word bits 95..16 with the generator x^16+x^12+x^5+1, a zero preset and MSB-first feeding. A word passes when bits 15..0 equal the bitwise inverse of that remainder.
- R4: When the 96th bit of a passing word arrives and no read is active or starting, the word is latched and the ready flag goes low. Outputs are registered and show the change one cycle later.
- R5: A failing word leaves the ready flag high and leaves the held word unchanged.
- R6: A block marker forces the ready flag high.
- R7: A read strobe while the flag is low starts a read and raises the flag. That strobe and each of the next 95 strobes present held bits 95 down to 0 on `sda_out`, one bit per strobe. The 97th strobe ends the read.
- R8: Read strobes while the flag is high and no read is active are ignored.
- R9: A word that passes during an active read, or in the cycle a read starts, is discarded. The held word stays stable for the whole read.
- R10: With `ready_on_status`=0, `sda_out` carries the ready flag when idle and `status_out` stays 1. With `ready_on_status`=1, `status_out` carries the flag and `sda_out` idles at 1. Read data always appears on `sda_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_bit | input | 1 | Q-channel data bit |
| q_stb | input | 1 | One-cycle strobe: q_bit is valid |
| blk_start | input | 1 | One-cycle marker: a new block begins |
| rd_stb | input | 1 | Host read strobe |
| ready_on_status | input | 1 | 0: flag on sda_out, 1: flag on status_out |
| sda_out | output | 1 | Serial data / ready flag |
| status_out | output | 1 | Status pin / ready flag |

## Verification
The hardest state to reach is a passing word that completes while a read of the previous word is still under way. The read has to be started before the next block marker, because the marker raises the flag and blocks any new read. The stimulus therefore starts the read, then sends a full valid word with read strobes only on alternate bits, so the read is still active when the 96th bit lands. A cycle-accurate reference model in the bench then expects the new word to be discarded and the old word to finish reading out intact.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned Q_WORD_W = 96;
  localparam int unsigned Q_CRC_W  = 16;
  localparam logic [15:0] Q_POLY   = 16'h1021;
endpackage

// File: rtl/subq_crc_unit.sv
module subq_crc_unit #(
  parameter int unsigned CRC_W = subq_pkg::Q_CRC_W,
  parameter logic [CRC_W-1:0] POLY = subq_pkg::Q_POLY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, nxt;
  logic fb;

  assign fb = crc_q[CRC_W-1] ^ din;

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_mid
      assign nxt[i] = crc_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (en)    crc_q <= nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/subq_accum.sv
module subq_accum #(
  parameter int unsigned WORD_W = subq_pkg::Q_WORD_W,
  parameter int unsigned CRC_W  = subq_pkg::Q_CRC_W,
  parameter logic [CRC_W-1:0] POLY = subq_pkg::Q_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk,
  input  logic              stb,
  input  logic              din,
  output logic              word_ok,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_BODY = CNT_W'(WORD_W - CRC_W);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  rem;
  logic              take, last;

  assign take = stb && !blk && (cnt_q < CNT_FULL);
  assign last = take && (cnt_q == CNT_LAST);

  subq_crc_unit #(.CRC_W(CRC_W), .POLY(POLY)) i_crc (
    .clk(clk), .rst(rst), .clr(blk),
    .en(take && (cnt_q < CNT_BODY)), .din(din), .crc(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (blk) begin
      cnt_q <= '0;
    end else if (take) begin
      sr_q  <= {sr_q[WORD_W-2:0], din};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word    = {sr_q[WORD_W-2:0], din};
  assign word_ok = last && ({sr_q[CRC_W-2:0], din} == ~rem);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);
  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    blk |=> (cnt_q == '0));
  // R3
  ok_full_chk: assert property (@(posedge clk) disable iff (rst)
    word_ok |=> (cnt_q == CNT_FULL));
endmodule

// File: rtl/subq_readout.sv
module subq_readout #(
  parameter int unsigned WORD_W = subq_pkg::Q_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk,
  input  logic              rd_stb,
  input  logic              word_ok,
  input  logic [WORD_W-1:0] word,
  input  logic              sel,
  output logic              sda_o,
  output logic              stat_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, rd_sr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              reading_q, ready_n_q, sel_q, sda_q, stat_q;
  logic              start, load;

  assign start = rd_stb && !reading_q && !ready_n_q;
  assign load  = word_ok && !reading_q && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      rd_sr_q   <= '0;
      idx_q     <= '0;
      reading_q <= 1'b0;
      ready_n_q <= 1'b1;
      sel_q     <= 1'b0;
      sda_q     <= 1'b1;
      stat_q    <= 1'b1;
    end else begin
      sel_q  <= sel;
      sda_q  <= reading_q ? rd_sr_q[WORD_W-1] : (sel_q ? 1'b1 : ready_n_q);
      stat_q <= sel_q ? ready_n_q : 1'b1;
      if (reading_q && rd_stb) begin
        if (idx_q == IDX_LAST) begin
          reading_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          rd_sr_q <= {rd_sr_q[WORD_W-2:0], 1'b0};
        end
      end else if (start) begin
        reading_q <= 1'b1;
        idx_q     <= '0;
        rd_sr_q   <= hold_q;
      end
      if (load) begin
        hold_q    <= word;
        ready_n_q <= 1'b0;
      end else if (start || blk) begin
        ready_n_q <= 1'b1;
      end
    end
  end

  assign sda_o  = sda_q;
  assign stat_o = stat_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (reading_q && $past(reading_q)) |-> $stable(hold_q));
  // R4
  ready_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_n_q) |-> $past(word_ok));
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_n_q |-> !reading_q);
  // R6
  blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    blk |=> ready_n_q);
endmodule

// File: rtl/subq_validator.sv
module subq_validator #(
  parameter int unsigned WORD_W = subq_pkg::Q_WORD_W,
  parameter int unsigned CRC_W  = subq_pkg::Q_CRC_W,
  parameter logic [CRC_W-1:0] POLY = subq_pkg::Q_POLY
) (
  input  logic clk,
  input  logic rst,
  input  logic q_bit,
  input  logic q_stb,
  input  logic blk_start,
  input  logic rd_stb,
  input  logic ready_on_status,
  output logic sda_out,
  output logic status_out
);
  logic              ok;
  logic [WORD_W-1:0] word;

  subq_accum #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) i_accum (
    .clk(clk), .rst(rst), .blk(blk_start), .stb(q_stb), .din(q_bit),
    .word_ok(ok), .word(word)
  );

  subq_readout #(.WORD_W(WORD_W)) i_readout (
    .clk(clk), .rst(rst), .blk(blk_start), .rd_stb(rd_stb),
    .word_ok(ok), .word(word), .sel(ready_on_status),
    .sda_o(sda_out), .stat_o(status_out)
  );
endmodule

// File: tb/test_subq_validator.sv
module test_subq_validator;
  logic clk = 1'b0, rst = 1'b1;
  logic i_bit = 1'b0, i_stb = 1'b0, i_blk = 1'b0, i_rd = 1'b0, i_sel = 1'b0;
  logic sda, stat;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  subq_validator i_subq_validator (
    .clk(clk), .rst(rst), .q_bit(i_bit), .q_stb(i_stb), .blk_start(i_blk),
    .rd_stb(i_rd), .ready_on_status(i_sel), .sda_out(sda), .status_out(stat)
  );

  // reference model
  bit q[$];
  logic [95:0] m_hold = '0;
  bit m_reading = 0, m_ready_n = 1, m_sel = 0, e_sda = 1, e_stat = 1;
  int m_idx = 0;

  function automatic logic [15:0] crc_of(logic [79:0] p);
    logic [15:0] c = '0;
    for (int i = 79; i >= 0; i--) begin
      logic fb = c[15] ^ p[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [95:0] mk_word(logic [79:0] p);
    return {p, ~crc_of(p)};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_hold = '0; m_reading = 0; m_ready_n = 1; m_sel = 0;
      m_idx = 0; e_sda = 1; e_stat = 1;
    end else begin
      bit ok, start, old_r;
      logic [95:0] w;
      e_sda  = m_reading ? m_hold[95-m_idx] : (m_sel ? 1'b1 : m_ready_n);
      e_stat = m_sel ? m_ready_n : 1'b1;
      ok = 0;
      if (i_blk) q.delete();
      else if (i_stb && q.size() < 96) begin
        q.push_back(i_bit);
        if (q.size() == 96) begin
          for (int i = 0; i < 96; i++) w[95-i] = q[i];
          ok = (w[15:0] == ~crc_of(w[95:16]));
        end
      end
      start = i_rd && !m_reading && !m_ready_n;
      old_r = m_reading;
      if (old_r && i_rd) begin
        if (m_idx == 95) m_reading = 0; else m_idx++;
      end else if (start) begin
        m_reading = 1; m_idx = 0;
      end
      if (ok && !old_r && !start) begin m_hold = w; m_ready_n = 0; end
      else if (start || i_blk) m_ready_n = 1;
      m_sel = i_sel;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (sda !== e_sda || stat !== e_stat) begin
        fails++;
        $display("FAIL %s: sda/status actual=%b%b expected=%b%b at t=%0t",
                 cur_req, sda, stat, e_sda, e_stat, $time);
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic step(input bit b, input bit s, input bit d, input bit r);
    @(negedge clk); i_blk = b; i_stb = s; i_bit = d; i_rd = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  // marker with a coincident (ignored) strobe, then 96 bits, then extras
  task automatic feed(input logic [95:0] w, input int extra);
    step(1, 1, ~w[95], 0);
    for (int i = 0; i < 96; i++) begin step(0, 1, w[95-i], 0); step(0, 0, 0, 0); end
    for (int i = 0; i < extra; i++) begin step(0, 1, 1, 0); step(0, 0, 0, 0); end
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin step(0, 0, 0, 1); step(0, 0, 0, 0); end
  endtask

  initial begin
    logic [95:0] w;
    idle(4);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1"; idle(5);
    // R2 R3 R4: valid word, flag on sda
    cur_req = "R4"; feed(mk_word(80'h1234_5678_9ABC_DEF0_A55A), 0); idle(4);
    cur_req = "R7"; read_n(97); idle(4);
    // R5: corrupted check field
    cur_req = "R5"; w = mk_word(80'hFFFF_0000_1111_2222_3333); w[3] = ~w[3];
    feed(w, 0); idle(3);
    cur_req = "R8"; read_n(5); idle(3);
    // R6: marker drops a pending ready
    cur_req = "R6"; feed(mk_word(80'h0F0F_F0F0_1357_2468_ACE1), 0); idle(3);
    step(1, 0, 0, 0); step(0, 1, 1, 0); idle(3);
    cur_req = "R8"; read_n(4);
    // R2: restart mid-word, then valid word with trailing strobes
    cur_req = "R2"; step(1, 0, 0, 0);
    for (int i = 0; i < 30; i++) begin step(0, 1, i[0], 0); step(0, 0, 0, 0); end
    feed(mk_word(80'hDEAD_BEEF_0000_1111_7777), 6); idle(3);
    // R9: new valid word completes during a read
    cur_req = "R9"; step(0, 0, 0, 1); idle(1);
    w = mk_word(80'h8000_0000_0000_0000_0001);
    step(1, 0, 0, 0);
    for (int i = 0; i < 96; i++) begin step(0, 1, w[95-i], i[0]); step(0, 0, 0, 0); end
    idle(3); read_n(60); idle(3);
    // R10: flag moved to status pin
    cur_req = "R10"; i_sel = 1'b1; idle(3);
    feed(mk_word(80'h0000_0000_0000_0000_0000), 0); idle(3);
    read_n(97); idle(3);
    feed(mk_word(80'hC0FF_EE00_4242_9999_0A0A), 0); idle(3);
    i_sel = 1'b0; idle(3);
    cur_req = "R3"; read_n(97); idle(5);
    summary();
  end
endmodule